// File: doc/BRIEF.md
# System management mode sequencer

This block sequences a processor core into and out of system management mode. A pulse on the SMI input, taken while the core is in normal mode, makes the block store the whole architectural register bank into a save frame in memory. The frame sits at the programmable base register plus 0xFE00, and each register goes to a fixed word offset. The block writes one 32-bit word per bus transfer. It then walks the register bank once more and writes in the values the core needs to start its handler. It marks the mode as active on a dedicated output for as long as the core stays in it.

When the core decodes its resume instruction, it pulses the resume input. In system management mode, the block then reads every saved word back into the register bank. It reloads the base register from a frame word at offset 0xF8 and takes the privilege level from the restored stack-segment access word. After that it leaves the mode. A resume pulse in normal mode produces an invalid-opcode fault instead.

The register bank is seen through a flat read port that carries all slots, plus a single-word write port. The core must hold the bank still while the busy output is high.

Top module: `smm_seq`

## Requirements
- R1: After reset, smi_act_o, busy_o, mem_req_o and ud_fault_o are low, cpl_o is 0 and smbase_o is 0x30000.
- R2: An SMI pulse in normal mode produces exactly 39 write transfers, one per register slot, at address smbase + 0xFE00 + offset. Slot 0 (CR4) uses offset 0x128. Slots 1..18 (limit, base and access of ES, CS, SS, DS, FS, GS in that order) use offset 0x12C + 4*slot. Slots 19..24 (selectors ES..GS) use offset 0x1A8 + 4*(slot-19). Slots 25..38 (DR7, DR6, EAX, ECX, EDX, EBX, ESP, EBP, ESI, EDI, EIP, EFLAGS, CR3, CR0) use offset 0x1C8 + 4*(slot-25).
- R3: Each saved word equals the value the slot held before entry, including the unmodified CR0 (slot 38) and flags (slot 36).
- R4: After the save, the bank holds the entry values. Data segments get limit 0xFFFFFFFF, base 0, access 0x8093 and selector 0. CS gets limit 0xFFFFFFFF, base equal to smbase, access 0x809B and selector 0x3000. CR4 becomes 0, DR7 becomes 0x400, EIP becomes 0x8000 and EFLAGS becomes 0x2. CR0 has bits 31, 3, 2 and 0 cleared. All other slots are unchanged.
- R5: smi_act_o rises when the save starts and falls when the restore completes.
- R6: An SMI pulse while already in system management mode is ignored: no transfer, no bank write.
- R7: A resume pulse in system management mode produces 40 read transfers: the 39 slots at their R2 offsets, then offset 0xF8. Each slot read is written to that bank slot, and the 0xF8 word becomes the new smbase.
- R8: After a resume, cpl_o equals bits 14:13 of the restored SS access word (slot 9).
- R9: A resume pulse in normal mode raises ud_fault_o for exactly one cycle, with no transfer and no bank write.
- R10: mem_req_o is high only while busy_o is high. The address and direction stay stable until mem_ack_i is seen.
- R11: An SMI or resume pulse that arrives while a save or restore runs is kept and acted on once the running sequence finishes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smi_i | input | 1 | SMI request pulse |
| rsm_i | input | 1 | Resume instruction decoded |
| regs_i | input | 39*32 | Flat register bank, slot n in bits 32n+31:32n |
| wr_en_o | output | 1 | Bank write strobe |
| wr_idx_o | output | 6 | Bank write slot |
| wr_data_o | output | 32 | Bank write data |
| mem_req_o | output | 1 | Memory transfer request |
| mem_we_o | output | 1 | 1 for write, 0 for read |
| mem_addr_o | output | AW | Byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Transfer acknowledge |
| mem_rdata_i | input | 32 | Read data, valid with ack |
| smi_act_o | output | 1 | System management mode active |
| busy_o | output | 1 | Save, load or restore in progress |
| ud_fault_o | output | 1 | Invalid-opcode (vector 6) fault pulse |
| smbase_o | output | AW | Current base register |
| cpl_o | output | 2 | Current privilege level |

## Verification
The bench uses the default parameters: a 32-bit address and a reset base of 0x30000. It then reloads the base to 0x40000 through a resume, so both frame positions are exercised. With the 39-slot map, every save offset, every entry value and every restored word can be compared individually on each pass. An acknowledge delay of 0, 1 and 2 cycles covers the bus handshake. Requests are overlapped with a running save and a running restore to reach the hold-off paths.

// File: rtl/smm_seq_pkg.sv
package smm_seq_pkg;
  localparam int NSLOT     = 39;
  localparam int SLOT_W    = 6;
  localparam int WORD_W    = 32;
  localparam int SLOT_SS_ACC = 9;
  localparam int SLOT_SEL0 = 19;
  localparam int SLOT_SEL_CS = 20;
  localparam int SLOT_DR7  = 25;
  localparam int SLOT_EIP  = 35;
  localparam int SLOT_EFL  = 36;
  localparam int SLOT_CR0  = 38;
  localparam logic [8:0] OFS_BASE_WORD = 9'h0F8;
  localparam logic [WORD_W-1:0] CR0_CLR_MASK = 32'h8000_000D;

  typedef enum logic [1:0] {ST_IDLE, ST_SAVE, ST_LOAD, ST_RSTR} seq_st_e;

  function automatic logic [8:0] slot_off(input logic [SLOT_W-1:0] idx);
    logic [8:0] i9;
    i9 = {3'b000, idx};
    if (idx == 6'd0)       return 9'h128;
    else if (idx <= 6'd18) return 9'h12C + (i9 << 2);
    else if (idx <= 6'd24) return 9'h1A8 + ((i9 - 9'd19) << 2);
    else                   return 9'h1C8 + ((i9 - 9'd25) << 2);
  endfunction
endpackage

// File: rtl/smm_req_hold.sv
module smm_req_hold (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic take_i,
  output logic pend_o
);
  logic pend_q;

  assign pend_o = req_i | pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= take_i ? 1'b0 : pend_o;
  end

  AST_HOLD_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !take_i) |=> pend_o); // R11
endmodule

// File: rtl/smm_entry_gen.sv
module smm_entry_gen
  import smm_seq_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [SLOT_W-1:0] idx_i,
  input  logic [WORD_W-1:0] cur_i,
  input  logic [AW-1:0]     smbase_i,
  output logic [WORD_W-1:0] val_o
);
  logic [SLOT_W-1:0] d_idx, seg, fld;

  always_comb begin
    d_idx = idx_i - 6'd1;
    seg   = d_idx / 6'd3;
    fld   = d_idx % 6'd3;
    val_o = cur_i;
    if (idx_i == 6'd0) begin
      val_o = '0;
    end else if (idx_i <= 6'd18) begin
      unique case (fld)
        6'd0:    val_o = 32'hFFFF_FFFF;
        6'd1:    val_o = (seg == 6'd1) ? WORD_W'(smbase_i) : 32'h0;
        default: val_o = (seg == 6'd1) ? 32'h0000_809B : 32'h0000_8093;
      endcase
    end else if (idx_i < 6'(SLOT_DR7)) begin
      val_o = (idx_i == 6'(SLOT_SEL_CS)) ? 32'h0000_3000 : 32'h0;
    end else if (idx_i == 6'(SLOT_DR7)) begin
      val_o = 32'h0000_0400;
    end else if (idx_i == 6'(SLOT_EIP)) begin
      val_o = 32'h0000_8000;
    end else if (idx_i == 6'(SLOT_EFL)) begin
      val_o = 32'h0000_0002;
    end else if (idx_i == 6'(SLOT_CR0)) begin
      val_o = cur_i & ~CR0_CLR_MASK;
    end
  end
endmodule

// File: rtl/smm_frame_addr.sv
module smm_frame_addr
  import smm_seq_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0]     frame_i,
  input  logic [SLOT_W-1:0] idx_i,
  output logic [AW-1:0]     addr_o
);
  logic [8:0] ofs;

  always_comb begin
    ofs    = (idx_i == 6'(NSLOT)) ? OFS_BASE_WORD : slot_off(idx_i);
    addr_o = frame_i + AW'(ofs);
  end
endmodule

// File: rtl/smm_seq.sv
module smm_seq
  import smm_seq_pkg::*;
#(
  parameter int          AW         = 32,
  parameter logic [31:0] SMBASE_RST = 32'h0003_0000,
  parameter logic [31:0] FRAME_OFS  = 32'h0000_FE00
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    smi_i,
  input  logic                    rsm_i,
  input  logic [NSLOT*WORD_W-1:0] regs_i,
  output logic                    wr_en_o,
  output logic [SLOT_W-1:0]       wr_idx_o,
  output logic [WORD_W-1:0]       wr_data_o,
  output logic                    mem_req_o,
  output logic                    mem_we_o,
  output logic [AW-1:0]           mem_addr_o,
  output logic [WORD_W-1:0]       mem_wdata_o,
  input  logic                    mem_ack_i,
  input  logic [WORD_W-1:0]       mem_rdata_i,
  output logic                    smi_act_o,
  output logic                    busy_o,
  output logic                    ud_fault_o,
  output logic [AW-1:0]           smbase_o,
  output logic [1:0]              cpl_o
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NSLOT - 1);
  localparam logic [SLOT_W-1:0] BASE_STEP = SLOT_W'(NSLOT);

  seq_st_e           state_q;
  logic [SLOT_W-1:0] idx_q, rd_idx;
  logic [AW-1:0]     frame_q, smbase_q;
  logic              smm_q, fault_q;
  logic [1:0]        cpl_q;
  logic              smi_ev, rsm_ev, smi_take, rsm_take, enter;
  logic [WORD_W-1:0] cur_word, entry_word;
  logic [10:0]       bit_ofs;

  assign enter    = (state_q == ST_IDLE) && smi_ev && !smm_q;
  assign smi_take = (state_q == ST_IDLE);
  assign rsm_take = (state_q == ST_IDLE) && !enter;

  smm_req_hold u_smi_hold (
    .clk_i (clk_i), .rst_ni(rst_ni), .req_i(smi_i), .take_i(smi_take), .pend_o(smi_ev)
  );
  smm_req_hold u_rsm_hold (
    .clk_i (clk_i), .rst_ni(rst_ni), .req_i(rsm_i), .take_i(rsm_take), .pend_o(rsm_ev)
  );

  assign rd_idx   = (idx_q < BASE_STEP) ? idx_q : '0;
  assign bit_ofs  = {rd_idx, 5'b00000};
  assign cur_word = regs_i[bit_ofs +: WORD_W];

  smm_entry_gen #(.AW(AW)) u_entry (
    .idx_i(idx_q), .cur_i(cur_word), .smbase_i(smbase_q), .val_o(entry_word)
  );

  smm_frame_addr #(.AW(AW)) u_addr (
    .frame_i(frame_q), .idx_i(idx_q), .addr_o(mem_addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      frame_q  <= '0;
      smbase_q <= AW'(SMBASE_RST);
      smm_q    <= 1'b0;
      fault_q  <= 1'b0;
      cpl_q    <= 2'd0;
    end else begin
      fault_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (enter) begin
            state_q <= ST_SAVE;
            idx_q   <= '0;
            frame_q <= smbase_q + AW'(FRAME_OFS);
            smm_q   <= 1'b1;
          end else if (rsm_ev) begin
            if (smm_q) begin
              state_q <= ST_RSTR;
              idx_q   <= '0;
              frame_q <= smbase_q + AW'(FRAME_OFS);
            end else begin
              fault_q <= 1'b1;
            end
          end
        end
        ST_SAVE: if (mem_ack_i) begin
          if (idx_q == LAST_SLOT) begin
            state_q <= ST_LOAD;
            idx_q   <= '0;
          end else begin
            idx_q <= idx_q + 6'd1;
          end
        end
        ST_LOAD: begin
          if (idx_q == LAST_SLOT) begin
            state_q <= ST_IDLE;
            cpl_q   <= 2'd0;
          end else begin
            idx_q <= idx_q + 6'd1;
          end
        end
        ST_RSTR: if (mem_ack_i) begin
          if (idx_q == 6'(SLOT_SS_ACC)) cpl_q <= mem_rdata_i[14:13];
          if (idx_q == BASE_STEP) begin
            smbase_q <= mem_rdata_i[AW-1:0];
            smm_q    <= 1'b0;
            state_q  <= ST_IDLE;
          end else begin
            idx_q <= idx_q + 6'd1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    wr_en_o   = 1'b0;
    wr_idx_o  = idx_q;
    wr_data_o = entry_word;
    if (state_q == ST_LOAD) begin
      wr_en_o = 1'b1;
    end else if (state_q == ST_RSTR) begin
      wr_en_o   = mem_ack_i && (idx_q < BASE_STEP);
      wr_data_o = mem_rdata_i;
    end
  end

  assign mem_req_o   = (state_q == ST_SAVE) || (state_q == ST_RSTR);
  assign mem_we_o    = (state_q == ST_SAVE);
  assign mem_wdata_o = cur_word;
  assign busy_o      = (state_q != ST_IDLE);
  assign smi_act_o   = smm_q;
  assign ud_fault_o  = fault_q;
  assign smbase_o    = smbase_q;
  assign cpl_o       = cpl_q;

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o))); // R10
  AST_WR_IN_SEQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (busy_o && !mem_we_o)); // R7
  AST_ACT_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(smi_act_o) |-> (busy_o && mem_req_o && mem_we_o)); // R5
  AST_ACT_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(smi_act_o) |-> ($past(mem_ack_i) && !$past(mem_we_o) && !busy_o)); // R5
  AST_SMI_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smi_act_o && !busy_o) |=> !(mem_req_o && mem_we_o)); // R6
  AST_FAULT_NORMAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ud_fault_o |-> (!smi_act_o && !busy_o)); // R9
endmodule

// File: tb/smm_seq_tb.sv
`timescale 1ns/1ps
module smm_seq_tb;
  localparam int NS = 39;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smi = 1'b0, rsm = 1'b0;
  logic [NS*32-1:0] regs;
  logic wr_en, mem_req, mem_we, mem_ack = 1'b0, smi_act, busy, ud_fault;
  logic [5:0] wr_idx;
  logic [31:0] wr_data, mem_addr, mem_wdata, mem_rdata = '0, smbase;
  logic [1:0] cpl;

  logic [31:0] bank [NS];
  logic [31:0] pre  [NS];
  logic [31:0] qv   [NS];
  logic [31:0] mem  [128];
  logic [31:0] sbase_exp;
  int ack_dly = 0, dcnt = 0;
  int n_cmp = 0, n_bad = 0;
  int nw = 0, nr = 0, nwr = 0, nflt = 0, bad_addr = 0, viol = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  always_comb for (int i = 0; i < NS; i++) regs[i*32 +: 32] = bank[i];

  smm_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .smi_i(smi), .rsm_i(rsm), .regs_i(regs),
    .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .smi_act_o(smi_act), .busy_o(busy), .ud_fault_o(ud_fault),
    .smbase_o(smbase), .cpl_o(cpl)
  );

  function automatic int exp_off(int i);
    if (i == 0) return 'h128;
    if (i <= 18) return 'h130 + 4 * (i - 1);
    if (i <= 24) return 'h1A8 + 4 * (i - 19);
    return 'h1C8 + 4 * (i - 25);
  endfunction

  function automatic logic [31:0] exp_entry(int i, logic [31:0] p, logic [31:0] sb);
    if (i == 0) return 32'h0;
    if (i <= 18) begin
      if ((i - 1) % 3 == 0) return 32'hFFFF_FFFF;
      if ((i - 1) % 3 == 1) return ((i - 1) / 3 == 1) ? sb : 32'h0;
      return ((i - 1) / 3 == 1) ? 32'h809B : 32'h8093;
    end
    if (i <= 24) return (i == 20) ? 32'h3000 : 32'h0;
    if (i == 25) return 32'h400;
    if (i == 35) return 32'h8000;
    if (i == 36) return 32'h2;
    if (i == 38) return p & 32'h7FFF_FFF2;
    return p;
  endfunction

  // memory model: frame-relative window, ack driven on falling edges
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (mem_req) begin
      if (dcnt >= ack_dly) begin
        logic [31:0] off;
        off = mem_addr - sbase_exp;
        if (off >= 32'd512 || off[1:0] != 2'b00) begin
          bad_addr++;
          mem_rdata = 32'h0;
        end else begin
          if (mem_we) mem[off[8:2]] = mem_wdata;
          mem_rdata = mem[off[8:2]];
        end
        mem_ack = 1'b1;
        dcnt = 0;
      end else begin
        dcnt++;
      end
    end
  end

  always @(posedge clk) begin
    if (mem_req && mem_ack) begin
      if (mem_we) nw++; else nr++;
    end
    if (mem_req && !busy) viol++;
    if (ud_fault) nflt++;
    if (wr_en) begin
      bank[wr_idx] <= wr_data;
      nwr++;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pulse_smi();
    @(negedge clk); smi = 1'b1;
    @(negedge clk); smi = 1'b0;
  endtask

  task automatic pulse_rsm();
    @(negedge clk); rsm = 1'b1;
    @(negedge clk); rsm = 1'b0;
  endtask

  task automatic wait_idle();
    int q = 0;
    while (q < 4) begin
      @(negedge clk);
      if (!busy) q++; else q = 0;
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    int w0, r0, f0, b0;
    for (int i = 0; i < NS; i++) begin
      bank[i] = 32'h1000_0000 + i * 32'h0101_0101;
      pre[i]  = bank[i];
      qv[i]   = 32'hA500_0000 + i * 32'h111;
    end
    bank[36] = 32'h0000_0246; pre[36] = bank[36];
    bank[38] = 32'hE000_001F; pre[38] = bank[38];
    qv[9] = 32'h0000_E093;
    for (int k = 0; k < 128; k++) mem[k] = 32'hDEAD_BEEF;

    repeat (3) @(negedge clk);
    chk("R1 smi_act", {31'd0, smi_act}, 32'd0);
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 mem_req", {31'd0, mem_req}, 32'd0);
    chk("R1 ud_fault", {31'd0, ud_fault}, 32'd0);
    chk("R1 smbase", smbase, 32'h0003_0000);
    chk("R1 cpl", {30'd0, cpl}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // entry from base 0x30000, zero-delay ack
    ack_dly = 0;
    sbase_exp = 32'h0003_0000 + 32'hFE00;
    pulse_smi();
    wait_idle();
    chk("R2 write count", nw, 39);
    chk("R2 frame address", bad_addr, 0);
    for (int i = 0; i < NS; i++) begin
      chk($sformatf("R3 saved slot %0d", i), mem[exp_off(i) >> 2], pre[i]);
      chk($sformatf("R4 entry slot %0d", i), bank[i], exp_entry(i, pre[i], 32'h0003_0000));
    end
    chk("R5 smi_act after entry", {31'd0, smi_act}, 32'd1);

    // SMI inside the mode
    w0 = nw; b0 = nwr;
    pulse_smi();
    wait_idle();
    chk("R6 no save writes", nw - w0, 0);
    chk("R6 no bank writes", nwr - b0, 0);
    chk("R6 eip kept", bank[35], 32'h8000);

    // resume with an edited frame and a new base
    for (int i = 0; i < NS; i++) mem[exp_off(i) >> 2] = qv[i];
    mem['hF8 >> 2] = 32'h0004_0000;
    ack_dly = 2;
    r0 = nr;
    pulse_rsm();
    wait_idle();
    chk("R7 read count", nr - r0, 40);
    for (int i = 0; i < NS; i++) chk($sformatf("R7 restored slot %0d", i), bank[i], qv[i]);
    chk("R7 new smbase", smbase, 32'h0004_0000);
    chk("R8 cpl from SS access", {30'd0, cpl}, 32'd3);
    chk("R5 smi_act after resume", {31'd0, smi_act}, 32'd0);
    chk("R7 frame address", bad_addr, 0);

    // resume outside the mode
    f0 = nflt; w0 = nw; r0 = nr; b0 = nwr;
    pulse_rsm();
    wait_idle();
    chk("R9 one fault pulse", nflt - f0, 1);
    chk("R9 no transfers", (nw - w0) + (nr - r0), 0);
    chk("R9 no bank writes", nwr - b0, 0);
    chk("R9 mode stays off", {31'd0, smi_act}, 32'd0);

    // resume pulse held off during a save at the new base
    ack_dly = 1;
    sbase_exp = 32'h0004_0000 + 32'hFE00;
    w0 = nw; r0 = nr;
    pulse_smi();
    repeat (3) @(negedge clk);
    chk("R11 busy during save", {31'd0, busy}, 32'd1);
    pulse_rsm();
    wait_idle();
    chk("R11 save then restore writes", nw - w0, 39);
    chk("R11 save then restore reads", nr - r0, 40);
    for (int i = 0; i < NS; i++) chk($sformatf("R11 round trip slot %0d", i), bank[i], qv[i]);
    chk("R11 mode off at end", {31'd0, smi_act}, 32'd0);
    chk("R8 cpl after round trip", {30'd0, cpl}, 32'd3);

    // SMI pulse held off during a restore
    pulse_smi();
    wait_idle();
    w0 = nw; r0 = nr;
    pulse_rsm();
    repeat (3) @(negedge clk);
    chk("R11 busy during restore", {31'd0, busy}, 32'd1);
    pulse_smi();
    wait_idle();
    chk("R11 re-entry writes", nw - w0, 39);
    chk("R11 restore reads", nr - r0, 40);
    chk("R11 mode on again", {31'd0, smi_act}, 32'd1);
    chk("R4 cs base new smbase", bank[5], 32'h0004_0000);
    chk("R4 eip entry", bank[35], 32'h8000);
    chk("R10 no request outside busy", viol, 0);
    chk("R2 frame address at new base", bad_addr, 0);

    done = 1'b1;
    finish_run();
  end
endmodule